// File: doc/BRIEF.md
# Burst-Capable Processor Bus Cycle Sequencer

This block is the bus-facing state machine of a 32-bit processor. The core hands it one request at a time: a kind (instruction fetch, aligned operand, misaligned operand), a direction, an address and, for writes, a data word. The sequencer turns the request into a cycle on the external bus. It drives an address strobe, a data strobe, a burst flag and a write flag, and it returns read words to the core.

Reads of the instruction stream and reads of misaligned operands run as four-word bursts. The address is strobed once, and then four 32-bit words come back with two clocks between each, and no new address phase. All other reads and every write run as a single three-clock cycle. A static configuration input models an address-translation stage. When it is set, one extra clock comes before the address phase of every cycle. The bus has no wait states, so every event falls on a fixed clock counted from acceptance.

Clocks are counted as follows. Clock 0 is the edge that accepts the request, and clock k is the k-th clock period after that edge.

Top module: `bus_burst_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A `req_valid` seen while `req_ready` is low is ignored: the cycle in progress keeps its address and timing, and no extra cycle follows it.
- R2: With `xlat_en` low, a single cycle asserts `bus_as` in clock 1 and `bus_ds` in clocks 2 and 3, and takes its data word in clock 3, for 3 clocks in total.
- R3: With `xlat_en` high, every event of every cycle moves one clock later. A single cycle then takes 4 clocks and a burst takes 10 clocks. No strobe is asserted and `req_ready` stays low in the added clock.
- R4: A read runs as a burst when `req_kind` is 2'b10 (instruction fetch) or 2'b01 (misaligned operand). A read with `req_kind` 2'b00 (aligned operand) or 2'b11 (reserved) runs as a single cycle.
- R5: A burst delivers four words, in clocks 3, 5, 7 and 9 (one clock later with translation), with `rd_valid` low in the clocks between them.
- R6: `bus_as` is high for exactly one clock per cycle. In that clock, `bus_addr` equals the request address.
- R7: `rd_addr` for word i (i = 0..3) keeps bits 31:4 of the request address and sets bits 3:0 to (request bits 3:0 + 4*i) mod 16.
- R8: For a burst, `bus_burst` is high from the `bus_as` clock through the clock of the fourth word. It is low at all other times and never high for a single cycle.
- R9: `rd_valid` pulses once per returned read word, with `rd_data` equal to `bus_rdata` in that clock. `done` pulses for one clock in the clock after the last data clock, and the sequencer is idle in that clock.
- R10: A write is always a single cycle, whatever its `req_kind`. `bus_write` is high from the `bus_as` clock through the data clock, `bus_wdata` carries the request data in those clocks, and `rd_valid` stays low.
- R11: While `rst_n` is low and until its release has passed the internal synchronizer, the sequencer is idle. In that state all strobes, `rd_valid` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xlat_en | input | 1 | Static: adds the translation clock before each address phase |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_kind | input | 2 | 00 aligned operand, 01 misaligned operand, 10 instruction fetch, 11 reserved |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | A read word is on `rd_data` |
| rd_data | output | 32 | Returned read word |
| rd_addr | output | 32 | Address of the word on `rd_data` |
| done | output | 1 | One-clock pulse after the final data clock |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_burst | output | 1 | Burst cycle indication |
| bus_write | output | 1 | Write cycle indication |
| bus_addr | output | 32 | Bus address, zero outside a bus cycle |
| bus_wdata | output | 32 | Bus write data, zero outside a write cycle |
| bus_rdata | input | 32 | Bus read data |

## Verification
The assertions assume three things about the inputs. Memory answers with no wait states. `xlat_en` changes only while the sequencer is idle. The bus returns a word in every data clock. The bench changes `xlat_en` only at the start of a transaction, while `req_ready` is high, and it drives `bus_rdata` in every clock. During a busy cycle it raises `req_valid` with a different address and drops it again before the sequencer returns to idle, so that stray request can only be ignored. It never leaves a request pending into the `done` clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    KIND_OPER  = 2'b00,
    KIND_MISAL = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_XLAT = 3'd1,
    ST_ADDR = 3'd2,
    ST_STRB = 3'd3,
    ST_DATA = 3'd4,
    ST_GAP  = 3'd5
  } seq_state_e;

  // Reads of the instruction stream or of misaligned operands go out as bursts
  function automatic logic wants_burst(input req_kind_e kind, input logic wr);
    return !wr && ((kind == KIND_MISAL) || (kind == KIND_FETCH));
  endfunction

endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bseq_req.sv
module bseq_req #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              wr_in,
  input  logic              burst_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q,
  output logic              burst_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
    end else if (load) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
      wr_q    <= wr_in;
      burst_q <= burst_in;
    end
  end

endmodule

// File: rtl/bseq_wrap.sv
module bseq_wrap #(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4,
  parameter int BYTES  = 4,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  output logic [ADDR_W-1:0] word_addr
);

  localparam int OFF_W   = $clog2(BEATS * BYTES);
  localparam int STEP_SH = $clog2(BYTES);

  generate
    if (OFF_W == 0) begin : g_flat
      assign word_addr = base;
    end else begin : g_wrap
      logic [OFF_W-1:0] step;
      logic [OFF_W-1:0] off;
      assign step = OFF_W'(beat) << STEP_SH;
      assign off  = base[OFF_W-1:0] + step;
      if (OFF_W == ADDR_W) begin : g_all
        assign word_addr = off;
      end else begin : g_hi
        assign word_addr = {base[ADDR_W-1:OFF_W], off};
      end
    end
  endgenerate

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              xlat_en,
  input  logic              burst_q,
  output seq_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              load,
  output logic              done
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              beat_en;
  logic              done_q, done_d;
  logic              last_word;

  assign last_word = !burst_q || (beat_q == LAST_BEAT);
  assign load      = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = xlat_en ? ST_XLAT : ST_ADDR;
      ST_XLAT: state_d = ST_ADDR;
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: state_d = ST_DATA;
      ST_DATA: state_d = last_word ? ST_IDLE : ST_GAP;
      ST_GAP:  state_d = ST_DATA;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    beat_en = 1'b0;
    beat_d  = beat_q;
    if (load) begin
      beat_en = 1'b1;
      beat_d  = '0;
    end else if ((state_q == ST_DATA) && !last_word) begin
      beat_en = 1'b1;
      beat_d  = beat_q + 1'b1;
    end
  end

  assign done_d = (state_q == ST_DATA) && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign state = state_q;
  assign beat  = beat_q;
  assign done  = done_q;

endmodule

// File: rtl/bus_burst_seq.sv
module bus_burst_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic              bus_as,
  output logic              bus_ds,
  output logic              bus_burst,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int BYTES  = DATA_W / 8;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              rst_int_n;
  seq_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              load;
  logic              burst_req;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic              burst_q;
  logic              bus_phase;

  bseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign burst_req = wants_burst(req_kind_e'(req_kind), req_write);

  bseq_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .wr_in    (req_write),
    .burst_in (burst_req),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .wr_q     (wr_q),
    .burst_q  (burst_q)
  );

  bseq_ctrl #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .xlat_en   (xlat_en),
    .burst_q   (burst_q),
    .state     (state),
    .beat      (beat),
    .load      (load),
    .done      (done)
  );

  bseq_wrap #(.ADDR_W(ADDR_W), .BEATS(BEATS), .BYTES(BYTES), .BEAT_W(BEAT_W)) u_wrap (
    .base      (addr_q),
    .beat      (beat),
    .word_addr (rd_addr)
  );

  assign bus_phase = (state == ST_ADDR) || (state == ST_STRB) ||
                     (state == ST_DATA) || (state == ST_GAP);

  assign req_ready = (state == ST_IDLE);
  assign bus_as    = (state == ST_ADDR);
  assign bus_ds    = (state == ST_STRB) || (state == ST_DATA) || (state == ST_GAP);
  assign bus_burst = bus_phase && burst_q;
  assign bus_write = bus_phase && wr_q;
  assign bus_addr  = bus_phase ? addr_q : '0;
  assign bus_wdata = (bus_phase && wr_q) ? wdata_q : '0;
  assign rd_valid  = (state == ST_DATA) && !wr_q;
  assign rd_data   = bus_rdata;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic bus_as,
  input logic bus_ds,
  input logic bus_burst,
  input logic bus_write,
  input logic rd_valid,
  input logic done
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_as || bus_ds || bus_burst || bus_write));

  assert_as_then_ds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |=> bus_ds);

  assert_word_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bus_burst) |=> !rd_valid);

  assert_as_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |=> !bus_as);

  assert_burst_starts_at_as_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_burst) |-> bus_as);

  assert_done_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_ds) && req_ready));

  assert_write_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> (!bus_burst && !rd_valid));

endmodule

bind bus_burst_seq bseq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_as    (bus_as),
  .bus_ds    (bus_ds),
  .bus_burst (bus_burst),
  .bus_write (bus_write),
  .rd_valid  (rd_valid),
  .done      (done)
);

// File: tb/bus_burst_seq_test.sv
module bus_burst_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xlat_en;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic        req_write;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [31:0] rd_addr;
  logic        done;
  logic        bus_as, bus_ds, bus_burst, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bus_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr), .done(done),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_burst(bus_burst), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input int x, input int kind, input bit wr,
                         input logic [31:0] a, input logic [31:0] wd, input bit junk);
    bit   burst;
    int   nw, first, last, idx;
    bit   in_bus, is_data;
    logic [31:0] exp_ra;
    burst = !wr && (kind == 1 || kind == 2);
    nw    = burst ? 4 : 1;
    first = 3 + x;
    last  = first + 2 * (nw - 1);
    @(negedge clk);
    xlat_en = x[0];
    chk("R1 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_kind  = kind[1:0];
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    for (int n = 1; n <= last + 3; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (junk && n == 2) begin
        req_valid = 1'b1;
        req_addr  = ~a;
        req_kind  = 2'b10;
        req_write = 1'b0;
      end
      if (n == 3) req_valid = 1'b0;
      bus_rdata = {16'hC0DE, n[7:0], a[7:0]};
      #1;
      in_bus  = (n >= 1 + x) && (n <= last);
      is_data = (n >= first) && (n <= last) && (((n - first) % 2) == 0);
      idx     = (n - first) / 2;
      chk("R1 R3 ready", {31'd0, req_ready}, {31'd0, n > last});
      chk("R2 R3 R6 bus_as", {31'd0, bus_as}, {31'd0, n == 1 + x});
      chk("R2 R3 bus_ds", {31'd0, bus_ds}, {31'd0, (n >= 2 + x) && (n <= last)});
      chk("R4 R8 bus_burst", {31'd0, bus_burst}, {31'd0, burst && in_bus});
      chk("R10 bus_write", {31'd0, bus_write}, {31'd0, wr && in_bus});
      chk("R5 R9 rd_valid", {31'd0, rd_valid}, {31'd0, is_data && !wr});
      chk("R9 done", {31'd0, done}, {31'd0, n == last + 1});
      if (n == 1 + x) chk("R6 bus_addr", bus_addr, a);
      if (wr && in_bus) chk("R10 bus_wdata", bus_wdata, wd);
      if (is_data && !wr) begin
        exp_ra = {a[31:4], 4'(a[3:0] + 4'(4 * idx))};
        chk("R7 rd_addr", rd_addr, exp_ra);
        chk("R9 rd_data", rd_data, bus_rdata);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int offs [5] = '{0, 4, 8, 12, 6};
    rst_n     = 1'b0;
    xlat_en   = 1'b0;
    req_valid = 1'b0;
    req_kind  = 2'b00;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    bus_rdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R11 strobes in reset", {28'd0, bus_as, bus_ds, bus_burst, bus_write}, 32'd0);
    chk("R11 rd_valid done in reset", {30'd0, rd_valid, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle after release", {31'd0, req_ready}, 32'd1);
    for (int x = 0; x < 2; x++)
      for (int k = 0; k < 4; k++)
        for (int w = 0; w < 2; w++)
          for (int o = 0; o < 5; o++)
            run_txn(x, k, w[0], 32'h0001_2340 + 32'(offs[o]) + 32'(k << 8),
                    32'hA5A5_0000 + 32'(o * 16 + k), o[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule